// File: doc/BRIEF.md
# SPI Master Controller with Memory-Mapped Registers

This block is a single-word SPI master. Software programs a 32-bit control word that selects the serial clock's idle level and sampling edge, the bit order, internal loopback, the word length and a two-stage clock prescaler. A write to the transmit register queues one word. The engine shifts that word out on `mosi_o` and gathers the same number of bits from `miso_i`. When the last edge has passed, the received word is placed in the receive register and a "receive ready" event is raised. The event can be routed to `irq_o` through a mask register.

The transmit register holds one word, and so does the receive register. A "transmit free" event shows when the transmit register can take another word. Both events are sticky and are cleared by writing 1 to them. An alignment option places short words in the upper part of the data registers. The controller acts as master only. Chip selects are driven outside the block.

Top module: `spi_host_ctrl`

## Requirements
- R1: After synchronous reset the control word reads 0, the event register reads 0x00000100 (transmit free set, receive ready clear), `irq_o` is 0 and `sck_o` is 0.
- R2: The register word addresses are control=0, transmit=1, receive=2, event=3, mask=4, command=5. The control word bits are: loopback 30, clock idle high 29, late sampling phase 28, extra divide-by-16 27, MSB-first 26, master 25, enable 24, length code 23:20, prescale 19:16, alignment 14. These bits read back as written, and every other bit reads 0. The command register reads 0.
- R3: A length code L from 3 to 15 gives words of L+1 bits, and L=0 gives 32-bit words. Each word produces exactly twice that many `sck_o` edges.
- R4: Each `sck_o` half period lasts 2*(prescale+1) clock cycles, multiplied by 16 when the divide-by-16 bit is set. The slowest setting gives a serial clock of clk/1024.
- R5: Between words, `sck_o` rests at the clock-idle-high bit. When the phase bit is 0, the first bit is on `mosi_o` before the first edge, and both sides sample on leading edges. When the phase bit is 1, data changes on leading edges and is sampled on trailing edges.
- R6: With MSB-first set, bit n-1 of the word goes out first. With it clear, bit 0 goes out first. Received bits are assembled in the same order, right-aligned, and the unused upper bits are 0.
- R7: When loopback is set, the receive input is taken from the internal transmit output, so the received word equals the transmitted word masked to n bits, whatever `miso_i` does.
- R8: Receive ready (event bit 9) is set when a word completes. Writing 1 to bit 9 clears it, and writing 0 leaves it set. `irq_o` is 1 when (event AND mask) is nonzero, using the same bit positions.
- R9: Transmit free (event bit 8) is cleared by a transmit write and set again when the queued word moves into the shifter.
- R10: While enable is 0, a queued word does not start, `sck_o` does not toggle and receive ready stays clear. Setting enable then starts the queued word.
- R11: With the alignment bit set and words shorter than 32 bits, the following placements apply. MSB-first words of up to 8 bits are transmitted from bits 31:24, and words of 9 to 16 bits from bits 31:16. Received MSB-first words are returned shifted left by 16. LSB-first transmit data is right-aligned. LSB-first received words are returned shifted left by 8 for lengths up to 8 and unshifted for longer ones. 32-bit words are never shifted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after a read strobe |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the control word is not rewritten while a word is in flight. This matters most for the idle-level check at the end of a word, because it compares `sck_o` with the live clock-idle-high bit. They also assume that only legal length codes are used. The stimulus always writes the control word first with enable clear and then again with it set, and only then queues a word. It waits for receive ready before touching the control word again, and it uses only lengths of 4 to 16 bits or 32 bits. The bench's serial slave model changes `miso_i` only on the negative clock edge after it sees an `sck_o` edge, which keeps the serial inputs well away from the master's sampling edge.

// File: rtl/spi_host_pkg.sv
`timescale 1ns/1ps
package spi_host_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned IDX_W  = $clog2(WORD_W);
  localparam int unsigned CNT_W  = IDX_W + 1;

  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_TXD  = 3'd1,
    RA_RXD  = 3'd2,
    RA_EVT  = 3'd3,
    RA_MSK  = 3'd4,
    RA_CMD  = 3'd5
  } reg_addr_e;

  localparam int unsigned B_LOOP  = 30;
  localparam int unsigned B_CPOL  = 29;
  localparam int unsigned B_CPHA  = 28;
  localparam int unsigned B_DIV   = 27;
  localparam int unsigned B_MSBF  = 26;
  localparam int unsigned B_MSTR  = 25;
  localparam int unsigned B_EN    = 24;
  localparam int unsigned B_LEN   = 20;
  localparam int unsigned B_PM    = 16;
  localparam int unsigned B_ALIGN = 14;
  localparam int unsigned B_RDY   = 9;
  localparam int unsigned B_FREE  = 8;
endpackage

// File: rtl/spi_rate_gen.sv
`timescale 1ns/1ps
module spi_rate_gen #(
  parameter int PM_W    = 4,
  parameter int PRE_DIV = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            div_en,
  input  logic [PM_W-1:0] pm,
  output logic            tick
);
  localparam int RW = $clog2(2 * PRE_DIV * (2 ** PM_W)) + 1;

  logic [RW-1:0] cnt_q;
  logic [RW-1:0] base;
  logic [RW-1:0] half_m1;

  always_comb begin
    base    = (RW'(pm) + RW'(1)) << 1;
    half_m1 = (div_en ? base * RW'(PRE_DIV) : base) - RW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q == half_m1) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + RW'(1);
      tick  <= 1'b0;
    end
  end

  // R4: every half period is at least two cycles long
  p_tick_gap_r4: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/spi_word_engine.sv
`timescale 1ns/1ps
module spi_word_engine
  import spi_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              msbf,
  input  logic              loop,
  input  logic [CNT_W-1:0]  nbits,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              miso,
  input  logic              tick,
  output logic              take,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word,
  output logic              sck,
  output logic              mosi
);
  logic              busy_q, ph_q, done_q, sck_q, mosi_q;
  logic              msbf_q, cpha_q;
  logic [WORD_W-1:0] txw_q, rx_q;
  logic [CNT_W-1:0]  nb_q, idx_q;
  logic [CNT_W:0]    edge_q, last_edge;
  logic              sin;

  function automatic logic [IDX_W-1:0] bpos(input logic r,
                                            input logic [CNT_W-1:0] nb,
                                            input logic [CNT_W-1:0] i);
    logic [CNT_W-1:0] p;
    p = r ? (nb - CNT_W'(1) - i) : i;
    return p[IDX_W-1:0];
  endfunction

  assign take      = start && en && !busy_q;
  assign sin       = loop ? mosi_q : miso;
  assign last_edge = {nb_q, 1'b0} - (CNT_W + 1)'(1);

  always_ff @(posedge clk) begin
    done_q <= 1'b0;
    if (rst) begin
      busy_q <= 1'b0;  ph_q   <= 1'b0;  sck_q <= 1'b0;  mosi_q <= 1'b0;
      msbf_q <= 1'b0;  cpha_q <= 1'b0;  txw_q <= '0;    rx_q   <= '0;
      nb_q   <= '0;    idx_q  <= '0;    edge_q <= '0;
    end else if (!en) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      sck_q  <= cpol;
    end else if (take) begin
      busy_q <= 1'b1;
      ph_q   <= 1'b0;
      edge_q <= '0;
      idx_q  <= '0;
      txw_q  <= tx_word;
      nb_q   <= nbits;
      msbf_q <= msbf;
      cpha_q <= cpha;
      rx_q   <= '0;
      mosi_q <= tx_word[bpos(msbf, nbits, '0)];
      sck_q  <= cpol;
    end else if (busy_q && tick) begin
      ph_q   <= ~ph_q;
      sck_q  <= cpol ^ ~ph_q;
      edge_q <= edge_q + (CNT_W + 1)'(1);
      if (!ph_q) begin
        if (!cpha_q) rx_q[bpos(msbf_q, nb_q, idx_q)] <= sin;
        else         mosi_q <= txw_q[bpos(msbf_q, nb_q, idx_q)];
      end else begin
        if (cpha_q) rx_q[bpos(msbf_q, nb_q, idx_q)] <= sin;
        idx_q <= idx_q + CNT_W'(1);
        if (!cpha_q && (idx_q + CNT_W'(1)) < nb_q)
          mosi_q <= txw_q[bpos(msbf_q, nb_q, idx_q + CNT_W'(1))];
      end
      if (edge_q == last_edge) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else if (!busy_q) begin
      sck_q <= cpol;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_word = rx_q;
  assign sck     = sck_q;
  assign mosi    = mosi_q;

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R10: a disabled engine never becomes busy
  p_no_start_off_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> !busy_q);
  // R5: the serial clock is back at its idle level when a word ends
  p_idle_at_end_r5: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (sck_q == cpol));
endmodule

// File: rtl/spi_host_ctrl.sv
`timescale 1ns/1ps
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int PM_W    = 4,
  parameter int LEN_W   = 4,
  parameter int PRE_DIV = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              irq_o
);
  localparam int unsigned HI_BYTE = WORD_W - 8;
  localparam int unsigned HI_HALF = WORD_W - 16;

  logic loop_q, cpol_q, cpha_q, div_q, msbf_q, mstr_q, en_q, align_q;
  logic [LEN_W-1:0] len_q;
  logic [PM_W-1:0]  pm_q;
  logic rdy_q, free_q, mrdy_q, mfree_q, irq_q, pend_q;
  logic [WORD_W-1:0] txbuf_q, rxreg_q, ctrl_img, rd_mux;
  logic wr_ctrl, wr_tx, wr_evt, wr_msk, rd_any;
  logic [CNT_W-1:0]  nbits;
  logic              full_w, short8;
  logic [WORD_W-1:0] eng_tx, eng_rx, rx_aligned;
  logic eng_take, eng_busy, eng_done, tick;

  assign wr_ctrl = reg_sel && reg_we && (reg_addr == ADDR_W'(RA_CTRL));
  assign wr_tx   = reg_sel && reg_we && (reg_addr == ADDR_W'(RA_TXD));
  assign wr_evt  = reg_sel && reg_we && (reg_addr == ADDR_W'(RA_EVT));
  assign wr_msk  = reg_sel && reg_we && (reg_addr == ADDR_W'(RA_MSK));
  assign rd_any  = reg_sel && !reg_we;

  always_comb begin
    full_w = (len_q == '0);
    nbits  = full_w ? CNT_W'(WORD_W) : CNT_W'(len_q) + CNT_W'(1);
    short8 = (nbits <= CNT_W'(8));
    eng_tx = txbuf_q;
    if (align_q && !full_w && msbf_q)
      eng_tx = short8 ? (txbuf_q >> HI_BYTE) : (txbuf_q >> HI_HALF);
    rx_aligned = eng_rx;
    if (align_q && !full_w) begin
      if (msbf_q)      rx_aligned = eng_rx << HI_HALF;
      else if (short8) rx_aligned = eng_rx << 8;
    end
  end

  always_comb begin
    ctrl_img = '0;
    ctrl_img[B_LOOP]  = loop_q;
    ctrl_img[B_CPOL]  = cpol_q;
    ctrl_img[B_CPHA]  = cpha_q;
    ctrl_img[B_DIV]   = div_q;
    ctrl_img[B_MSBF]  = msbf_q;
    ctrl_img[B_MSTR]  = mstr_q;
    ctrl_img[B_EN]    = en_q;
    ctrl_img[B_LEN +: LEN_W] = len_q;
    ctrl_img[B_PM +: PM_W]   = pm_q;
    ctrl_img[B_ALIGN] = align_q;
    rd_mux = '0;
    case (reg_addr)
      ADDR_W'(RA_CTRL): rd_mux = ctrl_img;
      ADDR_W'(RA_RXD):  rd_mux = rxreg_q;
      ADDR_W'(RA_EVT):  begin rd_mux[B_RDY] = rdy_q;  rd_mux[B_FREE] = free_q;  end
      ADDR_W'(RA_MSK):  begin rd_mux[B_RDY] = mrdy_q; rd_mux[B_FREE] = mfree_q; end
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {loop_q, cpol_q, cpha_q, div_q, msbf_q, mstr_q, en_q, align_q} <= '0;
      len_q <= '0;  pm_q <= '0;
    end else if (wr_ctrl) begin
      loop_q  <= reg_wdata[B_LOOP];
      cpol_q  <= reg_wdata[B_CPOL];
      cpha_q  <= reg_wdata[B_CPHA];
      div_q   <= reg_wdata[B_DIV];
      msbf_q  <= reg_wdata[B_MSBF];
      mstr_q  <= reg_wdata[B_MSTR];
      en_q    <= reg_wdata[B_EN];
      len_q   <= reg_wdata[B_LEN +: LEN_W];
      pm_q    <= reg_wdata[B_PM +: PM_W];
      align_q <= reg_wdata[B_ALIGN];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txbuf_q <= '0;  pend_q <= 1'b0;  rxreg_q <= '0;
      rdy_q <= 1'b0;  free_q <= 1'b1;
      mrdy_q <= 1'b0; mfree_q <= 1'b0;
      irq_q <= 1'b0;  reg_rdata <= '0;
    end else begin
      if (wr_tx) begin
        txbuf_q <= reg_wdata;
        pend_q  <= 1'b1;
      end else if (eng_take) begin
        pend_q  <= 1'b0;
      end
      if (wr_tx)                            free_q <= 1'b0;
      else if (eng_take)                    free_q <= 1'b1;
      else if (wr_evt && reg_wdata[B_FREE]) free_q <= 1'b0;
      if (eng_done) begin
        rxreg_q <= rx_aligned;
        rdy_q   <= 1'b1;
      end else if (wr_evt && reg_wdata[B_RDY]) begin
        rdy_q   <= 1'b0;
      end
      if (wr_msk) begin
        mrdy_q  <= reg_wdata[B_RDY];
        mfree_q <= reg_wdata[B_FREE];
      end
      irq_q <= (rdy_q && mrdy_q) || (free_q && mfree_q);
      if (rd_any) reg_rdata <= rd_mux;
    end
  end

  spi_rate_gen #(.PM_W(PM_W), .PRE_DIV(PRE_DIV)) u_rate (
    .clk(clk), .rst(rst), .run(eng_busy), .div_en(div_q), .pm(pm_q), .tick(tick)
  );

  spi_word_engine u_eng (
    .clk(clk), .rst(rst), .en(en_q), .cpol(cpol_q), .cpha(cpha_q),
    .msbf(msbf_q), .loop(loop_q), .nbits(nbits), .start(pend_q),
    .tx_word(eng_tx), .miso(miso_i), .tick(tick), .take(eng_take),
    .busy(eng_busy), .done(eng_done), .rx_word(eng_rx), .sck(sck_o),
    .mosi(mosi_o)
  );

  assign irq_o = irq_q;

  // R9: loading a word into the shifter frees the transmit register
  p_free_on_take_r9: assert property (@(posedge clk) disable iff (rst)
    eng_take && !wr_tx |=> free_q);
  // R8: a finished word with receive ready unmasked raises the interrupt
  p_irq_after_done_r8: assert property (@(posedge clk) disable iff (rst)
    eng_done && mrdy_q && !wr_msk |=> ##1 irq_o);
  // R10: nothing leaves the queue while disabled
  p_hold_when_off_r10: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !eng_take);
endmodule

// File: tb/sim_spi_host_ctrl.sv
`timescale 1ns/1ps
module sim_spi_host_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_sel = 1'b0, reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        sck_o, mosi_o, irq_o;
  logic        miso_i = 1'b0;

  int          nchk = 0, nbad = 0;
  int          ecnt, gmin, gmax;
  logic [31:0] cap, rxv, v, seed = 32'h1234_5678;

  localparam logic [2:0] A_CTRL = 3'd0, A_TXD = 3'd1, A_RXD = 3'd2,
                         A_EVT = 3'd3, A_MSK = 3'd4, A_CMD = 3'd5;

  always #5 clk = ~clk;

  spi_host_ctrl u0 (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] msk(input int n);
    return (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  function automatic int bp(input int n, input bit rv, input int k);
    return rv ? n - 1 - k : k;
  endfunction

  function automatic logic [31:0] mk(input bit lp, cp, ph, dv, rv, en,
                                     input int n, input int pm, input bit al);
    logic [3:0] len;
    logic [3:0] p4;
    len = (n == 32) ? 4'd0 : 4'(n - 1);
    p4  = 4'(pm);
    return {1'b0, lp, cp, ph, dv, rv, 1'b1, en, len, p4, 1'b0, al, 14'd0};
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_sel = 1'b0;
    d = reg_rdata;
  endtask

  // serial slave: shifts out slv, captures mosi, measures edge spacing
  task automatic slave_run(input int n, input bit ph, input bit rv, input logic [31:0] slv);
    logic prev;
    int   gap, k, p;
    prev = sck_o; gap = 0; ecnt = 0; gmin = 100000; gmax = 0; cap = 32'd0;
    for (int g = 0; g < 60000 && ecnt < 2 * n; g++) begin
      @(negedge clk);
      gap++;
      if (sck_o !== prev) begin
        prev = sck_o;
        if (ecnt > 0) begin
          if (gap < gmin) gmin = gap;
          if (gap > gmax) gmax = gap;
        end
        gap = 0;
        ecnt++;
        k = (ecnt - 1) / 2;
        if ((ecnt % 2 == 1) != ph) begin
          p = bp(n, rv, k);
          cap[p[4:0]] = mosi_o;
        end
        if (!ph && (ecnt % 2 == 0) && (ecnt / 2 < n)) begin
          p = bp(n, rv, ecnt / 2);
          miso_i = slv[p[4:0]];
        end
        if (ph && (ecnt % 2 == 1)) begin
          p = bp(n, rv, k);
          miso_i = slv[p[4:0]];
        end
      end
    end
  endtask

  task automatic poll_rdy();
    logic [31:0] e;
    for (int i = 0; i < 30000; i++) begin
      rd(A_EVT, e);
      if (e[9]) break;
    end
  endtask

  // do_tx=1: queue txw; do_tx=0: the word is already queued, write ctrl to enable
  task automatic go(input int n, input bit ph, input bit rv, input logic [31:0] slv,
                    input bit do_tx, input logic [31:0] d);
    int p;
    p = bp(n, rv, 0);
    miso_i = slv[p[4:0]];
    fork
      slave_run(n, ph, rv, slv);
      begin
        if (do_tx) wr(A_TXD, d); else wr(A_CTRL, d);
        poll_rdy();
      end
    join
    rd(A_RXD, rxv);
  endtask

  task automatic run_word(input bit lp, cp, ph, dv, rv, al, input int n, input int pm,
                          input logic [31:0] txw, input logic [31:0] slv);
    logic [31:0] m;
    m = mk(lp, cp, ph, dv, rv, 1'b1, n, pm, al);
    wr(A_CTRL, m & ~32'h0100_0000);
    wr(A_CTRL, m);
    wr(A_EVT, 32'hFFFF_FFFF);
    go(n, ph, rv, slv, 1'b1, txw);
  endtask

  initial begin
    #1_500_000;
    nbad++;
    $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    int lens[6] = '{4, 7, 8, 11, 16, 32};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rd(A_CTRL, v); check("R1 ctrl", v, 32'd0);
    rd(A_EVT, v);  check("R1 event", v, 32'h0000_0100);
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    check("R1 sck", {31'd0, sck_o}, 32'd0);

    // R2 readback of implemented control bits, command reads zero
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, v); check("R2 ctrl", v, 32'h7FFF_4000);
    wr(A_CTRL, 32'h0000_0000); rd(A_CTRL, v); check("R2 ctrl clr", v, 32'd0);
    wr(A_CMD, 32'hFFFF_FFFF);  rd(A_CMD, v);  check("R2 cmd", v, 32'd0);
    wr(A_MSK, 32'hFFFF_FFFF);  rd(A_MSK, v);  check("R2 mask", v, 32'h0000_0300);
    wr(A_MSK, 32'd0);

    // R3 R5 R6 sweep over modes and lengths
    for (int cp = 0; cp < 2; cp++)
      for (int ph = 0; ph < 2; ph++)
        for (int rv = 0; rv < 2; rv++)
          for (int li = 0; li < 6; li++) begin
            logic [31:0] t, s;
            int n;
            n = lens[li];
            seed = nxt(seed); t = seed;
            seed = nxt(seed); s = seed;
            run_word(1'b0, cp[0], ph[0], 1'b0, rv[0], 1'b0, n, 0, t, s);
            check("R3 edges", 32'(ecnt), 32'(2 * n));
            check("R5 mosi", cap, t & msk(n));
            check("R6 rx", rxv, s & msk(n));
            check("R4 half", 32'(gmax), 32'd2);
            check("R5 idle", {31'd0, sck_o}, 32'(cp));
          end

    // R4 prescale and divide-by-16
    for (int i = 0; i < 5; i++) begin
      int pm, dv, hp;
      pm = (i == 0) ? 1 : (i == 1) ? 5 : (i == 2) ? 15 : (i == 3) ? 0 : 15;
      dv = (i >= 3) ? 1 : 0;
      hp = 2 * (pm + 1) * (dv ? 16 : 1);
      run_word(1'b0, 1'b0, 1'b0, dv[0], 1'b1, 1'b0, 4, pm, 32'h5, 32'hA);
      check("R4 min", 32'(gmin), 32'(hp));
      check("R4 max", 32'(gmax), 32'(hp));
      check("R4 rx", rxv, 32'hA);
    end

    // R7 loopback ignores miso
    for (int li = 2; li < 6; li++) begin
      int n;
      n = lens[li];
      run_word(1'b1, 1'b0, li[0], 1'b0, 1'b1, 1'b0, n, 0, 32'hC3A5_5A3C, 32'h0F0F_0F0F);
      check("R7 loop", rxv, 32'hC3A5_5A3C & msk(n));
    end

    // R11 alternate alignment
    for (int rv = 0; rv < 2; rv++)
      for (int li = 2; li < 6; li++) begin
        int n;
        logic [31:0] raw, tw, er;
        n = lens[li];
        raw = 32'h0000_B36D & msk(n);
        if (n == 32) raw = 32'hD00D_F00D;
        tw = raw;
        if (rv && n != 32) tw = (n <= 8) ? raw << 24 : raw << 16;
        er = raw;
        if (n != 32) er = rv ? raw << 16 : ((n <= 8) ? raw << 8 : raw);
        run_word(1'b0, 1'b0, 1'b0, 1'b0, rv[0], 1'b1, n, 0, tw, raw);
        check("R11 tx", cap, raw);
        check("R11 rx", rxv, er);
      end

    // R8 receive ready, write-one-to-clear and interrupt
    wr(A_MSK, 32'h0000_0200);
    run_word(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8, 0, 32'h3C, 32'h96);
    repeat (3) @(negedge clk);
    check("R8 irq set", {31'd0, irq_o}, 32'd1);
    wr(A_EVT, 32'd0); rd(A_EVT, v); check("R8 w0 keeps", v, 32'h0000_0300);
    wr(A_EVT, 32'h0000_0200); rd(A_EVT, v); check("R8 w1c", v, 32'h0000_0100);
    repeat (2) @(negedge clk);
    check("R8 irq clr", {31'd0, irq_o}, 32'd0);
    wr(A_MSK, 32'h0000_0100);
    repeat (3) @(negedge clk);
    check("R8 irq free", {31'd0, irq_o}, 32'd1);
    wr(A_MSK, 32'd0);

    // R10 and R9: queue while disabled, then enable
    begin
      logic [31:0] m;
      int toggles;
      logic s0;
      m = mk(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8, 0, 1'b0);
      wr(A_CTRL, m);
      wr(A_EVT, 32'hFFFF_FFFF);
      wr(A_TXD, 32'h0000_00E7);
      s0 = sck_o; toggles = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (sck_o !== s0) toggles++;
      end
      check("R10 no sck", 32'(toggles), 32'd0);
      rd(A_EVT, v); check("R9 free clr, R10 not ready", v, 32'd0);
      go(8, 1'b0, 1'b1, 32'h0000_0042, 1'b0, m | 32'h0100_0000);
      check("R10 mosi", cap, 32'h0000_00E7);
      check("R10 rx", rxv, 32'h0000_0042);
      rd(A_EVT, v); check("R9 free set", v, 32'h0000_0300);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule